// File: doc/BRIEF.md
# Synchronous Burst Word Memory with Lane Writes

This block is a clocked static memory of 32-bit words. Every control input, the address and the write data are captured on the rising clock edge. Either of two address strobes starts an access: the address on the bus is loaded, and a 2-bit burst counter then produces the next three word positions of a four-word group each time the advance input is asserted. The counter either counts up and wraps within the group, or XORs its count into the starting low bits. A level on the mode input picks between the two.

Read data is not registered on the way out. The word at the current burst address appears on the output in the same cycle that the address register changes. The output drive is enabled only when the output enable is low, the device is selected, no write is waiting to complete and sleep is low. When the drive is off, the output is held at zero. Writes go per byte lane or to the whole word. They are captured at one edge and committed to the array at the following edge.

Selection needs three chip selects to agree. Dropping selection stops the output after one edge. Regaining selection takes two edges before the output is driven again. A sleep level freezes all synchronous state and keeps the stored words.

Top module: `burst_sram`

## Requirements
- R1: A start is selecting only when `chipSelN`=0, `chipSelHi`=1 and `chipSelLoN`=0. A start with any of the three wrong turns `dataDrive` off after that same edge.
- R2: After a selecting start that follows a deselected state, `dataDrive` stays 0 in the cycle after that edge. It becomes 1 after the next edge.
- R3: With `globalWriteN`=1, lane k (bits 8k+7:8k, k=0..3) is written only when `byteWriteN`=0 and `laneEnN[k]`=0. The other lanes keep their data.
- R4: With `globalWriteN`=0, all four lanes are written whatever `byteWriteN` and `laneEnN` hold.
- R5: With `burstMode`=0, each advance adds one to the low two address bits, wrapping from 3 to 0, and the upper bits do not change.
- R6: With `burstMode`=1, the low two address bits after i advances equal the starting low bits XOR i.
- R7: `procStrobeN`=0 starts an access only when `chipSelN`=0. `ctrlStrobeN`=0 always starts one.
- R8: With `advanceN`=1 and no start, the burst address holds.
- R9: Read data is flow-through. The word at the new burst address is on `dataOut` in the cycle right after the edge that sets that address.
- R10: `dataDrive` is 0, and `dataOut` is 0, while `outEnN`=1 or during the cycle after a write edge.
- R11: While `sleep`=1, strobes, advances and writes have no effect, `dataDrive` is 0 and stored words are kept.
- R12: A start at the same edge as an advance loads the new address with the burst count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of control state |
| addrIn | input | ADDR_W | Word address loaded on a start |
| dataIn | input | 32 | Write data |
| chipSelN | input | 1 | Primary chip select, active low |
| chipSelHi | input | 1 | Second chip select, active high |
| chipSelLoN | input | 1 | Third chip select, active low |
| procStrobeN | input | 1 | Address strobe gated by the primary select, active low |
| ctrlStrobeN | input | 1 | Ungated address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| byteWriteN | input | 1 | Master enable for lane writes, active low |
| laneEnN | input | 4 | Per-lane write enables, active low |
| globalWriteN | input | 1 | Whole-word write, active low |
| outEnN | input | 1 | Asynchronous output enable, active low |
| burstMode | input | 1 | 0 linear order, 1 XOR order |
| sleep | input | 1 | Freeze synchronous operation |
| dataOut | output | 32 | Read data, zero when not driven |
| dataDrive | output | 1 | Output driver enable |

## Verification
A start and an advance can land on the same edge. So can a write that goes to the current burst position and the flow-through read of the word the next edge brings up. The bench raises a strobe while the advance input is still low and expects the word at the new start address with no offset. It also reads each word back right after its write commits and expects the bus to stay off during the commit cycle. The word shown afterwards must be the merged word from the bench's own lane model.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;
  localparam int CNT_W  = 2;

  typedef struct packed {
    logic             load;
    logic             step;
    logic [LANES-1:0] wrLanes;
  } ctrl_t;

  function automatic logic [CNT_W-1:0] burstLow(input logic [CNT_W-1:0] seed,
                                                input logic [CNT_W-1:0] cnt,
                                                input logic interleave);
    return interleave ? (seed ^ cnt) : (seed + cnt);
  endfunction
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_sram_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chipSelN,
  input  logic             chipSelHi,
  input  logic             chipSelLoN,
  input  logic             procStrobeN,
  input  logic             ctrlStrobeN,
  input  logic             advanceN,
  input  logic             byteWriteN,
  input  logic [LANES-1:0] laneEnN,
  input  logic             globalWriteN,
  input  logic             outEnN,
  input  logic             sleep,
  input  logic             wrBusy,
  output ctrl_t            strobes,
  output logic             dataDrive
);
  logic selNow, startReq, awake, activeNow;
  logic selQ, driveQ;
  logic [LANES-1:0] laneHit;

  assign selNow    = !chipSelN && chipSelHi && !chipSelLoN;
  assign startReq  = !ctrlStrobeN || (!procStrobeN && !chipSelN);
  assign awake     = !sleep;
  assign activeNow = startReq ? selNow : selQ;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneHit[g] = !globalWriteN || (!byteWriteN && !laneEnN[g]);
  end

  always_comb begin
    strobes.load    = awake && startReq;
    strobes.step    = awake && !startReq && !advanceN;
    strobes.wrLanes = (awake && activeNow) ? laneHit : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selQ   <= 1'b0;
      driveQ <= 1'b0;
    end else if (awake) begin
      if (startReq) begin
        selQ   <= selNow;
        driveQ <= selNow && selQ;
      end else begin
        driveQ <= selQ;
      end
    end
  end

  assign dataDrive = driveQ && !wrBusy && !outEnN && awake;
endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctrl_t                   strobes,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [WORD_W-1:0]       dataIn,
  input  logic                    burstMode,
  input  logic                    dataDrive,
  output logic [WORD_W-1:0]       dataOut,
  output logic                    wrBusy,
  output logic [ADDR_W+CNT_W-1:0] burstState
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] baseQ, curAddr, tgtAddr, wrAddrQ;
  logic [CNT_W-1:0]  cntQ;
  logic [WORD_W-1:0] wrDataQ, readWord;
  logic [LANES-1:0]  wrMaskQ;

  assign curAddr    = {baseQ[ADDR_W-1:CNT_W], burstLow(baseQ[CNT_W-1:0], cntQ, burstMode)};
  assign tgtAddr    = strobes.load ? addrIn : curAddr;
  assign burstState = {baseQ, cntQ};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseQ   <= '0;
      cntQ    <= '0;
      wrBusy  <= 1'b0;
      wrAddrQ <= '0;
      wrDataQ <= '0;
      wrMaskQ <= '0;
    end else begin
      if (strobes.load) begin
        baseQ <= addrIn;
        cntQ  <= '0;
      end else if (strobes.step) begin
        cntQ <= cntQ + 1'b1;
      end
      wrBusy  <= |strobes.wrLanes;
      wrAddrQ <= tgtAddr;
      wrDataQ <= dataIn;
      wrMaskQ <= strobes.wrLanes;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gBank
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (wrBusy && wrMaskQ[g])
        laneMem[wrAddrQ] <= wrDataQ[g*LANE_W +: LANE_W];
    end
    assign readWord[g*LANE_W +: LANE_W] = laneMem[curAddr];
  end

  assign dataOut = dataDrive ? readWord : '0;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [31:0]       dataIn,
  input  logic              chipSelN,
  input  logic              chipSelHi,
  input  logic              chipSelLoN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              byteWriteN,
  input  logic [3:0]        laneEnN,
  input  logic              globalWriteN,
  input  logic              outEnN,
  input  logic              burstMode,
  input  logic              sleep,
  output logic [31:0]       dataOut,
  output logic              dataDrive
);
  ctrl_t strobes;
  logic  wrBusy;
  logic [ADDR_W+CNT_W-1:0] burstState;

  burst_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .chipSelN(chipSelN), .chipSelHi(chipSelHi), .chipSelLoN(chipSelLoN),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .byteWriteN(byteWriteN), .laneEnN(laneEnN), .globalWriteN(globalWriteN),
    .outEnN(outEnN), .sleep(sleep), .wrBusy(wrBusy),
    .strobes(strobes), .dataDrive(dataDrive)
  );

  burst_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .addrIn(addrIn),
    .dataIn(dataIn), .burstMode(burstMode), .dataDrive(dataDrive),
    .dataOut(dataOut), .wrBusy(wrBusy), .burstState(burstState)
  );
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              outEnN,
  input logic              dataDrive,
  input logic [31:0]       dataOut,
  input logic              ctrlStrobeN,
  input logic              procStrobeN,
  input logic              chipSelN,
  input logic              chipSelHi,
  input logic              chipSelLoN,
  input logic              advanceN,
  input logic [ADDR_W+1:0] burstState
);
  logic allSel;
  assign allSel = !chipSelN && chipSelHi && !chipSelLoN;

  assert_drive_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dataDrive |-> (!outEnN && !sleep));

  assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dataDrive |-> (dataOut == 32'h0));

  assert_sleep_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(burstState));

  assert_advance_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && advanceN && ctrlStrobeN && procStrobeN) |=> $stable(burstState));

  assert_proc_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && advanceN && ctrlStrobeN && !procStrobeN && chipSelN) |=> $stable(burstState));

  assert_deselect_fast_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !ctrlStrobeN && !allSel) |=> !dataDrive);

  assert_enable_slow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !ctrlStrobeN && !allSel) ##1 (!sleep && !ctrlStrobeN && allSel) |=> !dataDrive);
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .outEnN(outEnN),
  .dataDrive(dataDrive), .dataOut(dataOut), .ctrlStrobeN(ctrlStrobeN),
  .procStrobeN(procStrobeN), .chipSelN(chipSelN), .chipSelHi(chipSelHi),
  .chipSelLoN(chipSelLoN), .advanceN(advanceN), .burstState(burstState)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int AW = 4;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [31:0] dataIn = '0;
  logic chipSelN = 1, chipSelHi = 0, chipSelLoN = 1;
  logic procStrobeN = 1, ctrlStrobeN = 1, advanceN = 1;
  logic byteWriteN = 1, globalWriteN = 1, outEnN = 0, burstMode = 0, sleep = 0;
  logic [3:0] laneEnN = 4'hF;
  logic [31:0] dataOut;
  logic dataDrive;

  logic [31:0] model [NW];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  burst_sram #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn), .dataIn(dataIn),
    .chipSelN(chipSelN), .chipSelHi(chipSelHi), .chipSelLoN(chipSelLoN),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .byteWriteN(byteWriteN), .laneEnN(laneEnN), .globalWriteN(globalWriteN),
    .outEnN(outEnN), .burstMode(burstMode), .sleep(sleep),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic selectAll();
    chipSelN = 0; chipSelHi = 1; chipSelLoN = 0;
  endtask

  task automatic clearOps();
    ctrlStrobeN = 1; procStrobeN = 1; advanceN = 1;
    byteWriteN = 1; globalWriteN = 1; laneEnN = 4'hF;
  endtask

  function automatic logic [31:0] pattern(input int a);
    logic [7:0] b;
    b = 8'(a);
    return {b, 8'h5A, ~b, 8'hC3};
  endfunction

  function automatic logic [AW-1:0] burstAt(input logic [AW-1:0] s, input int i, input bit m);
    logic [1:0] low;
    low = m ? (s[1:0] ^ 2'(i)) : (s[1:0] + 2'(i));
    return {s[AW-1:2], low};
  endfunction

  task automatic writeWord(input string req, input int a, input logic [31:0] d,
                           input logic gwN, input logic bwN, input logic [3:0] lnN);
    logic [3:0] mask;
    selectAll();
    ctrlStrobeN = 0; addrIn = AW'(a); dataIn = d;
    globalWriteN = gwN; byteWriteN = bwN; laneEnN = lnN;
    step();
    clearOps();
    for (int k = 0; k < 4; k++)
      mask[k] = !gwN || (!bwN && !lnN[k]);
    if (mask != 4'h0) check({req, " R10 bus off while write commits"}, 32'(dataDrive), 32'h0);
    for (int k = 0; k < 4; k++)
      if (mask[k]) model[a][k*8 +: 8] = d[k*8 +: 8];
    step();
  endtask

  task automatic readWord(input string req, input int a);
    selectAll();
    ctrlStrobeN = 0; addrIn = AW'(a);
    step();
    clearOps();
    check({req, " R9 drive"}, 32'(dataDrive), 32'h1);
    check({req, " R9 data"}, dataOut, model[a]);
  endtask

  task automatic readBurst(input int s, input bit m);
    burstMode = m;
    readWord(m ? "R6 start" : "R5 start", s);
    for (int i = 1; i < 4; i++) begin
      advanceN = 0;
      step();
      check(m ? "R6 xor order" : "R5 linear order", dataOut, model[burstAt(AW'(s), i, m)]);
    end
    advanceN = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset drive", 32'(dataDrive), 32'h0);
    check("R10 reset bus", dataOut, 32'h0);
    rst_n = 1;
    step();

    for (int a = 0; a < NW; a++) writeWord("R4 fill", a, pattern(a), 1'b0, 1'b1, 4'hF);
    step();
    for (int a = 0; a < NW; a++) readWord("R4 fill readback", a);

    for (int s = 0; s < NW; s++) begin
      readBurst(s, 1'b0);
      readBurst(s, 1'b1);
    end
    burstMode = 0;

    for (int m = 0; m < 16; m++) begin
      writeWord("R3 lanes", 5, 32'h11223344 ^ {4{4'(m), 4'(~m)}}, 1'b1, 1'b0, 4'(m));
      readWord("R3 lane merge", 5);
    end
    writeWord("R3 master off", 6, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'h0);
    readWord("R3 master off keeps word", 6);
    writeWord("R4 global", 7, 32'hCAFE_F00D, 1'b0, 1'b1, 4'hF);
    readWord("R4 global all lanes", 7);
    writeWord("R4 global beats lanes", 7, 32'h1357_9BDF, 1'b0, 1'b0, 4'hE);
    readWord("R4 global beats lanes", 7);

    readWord("R8 setup", 10);
    for (int i = 0; i < 3; i++) begin
      step();
      check("R8 hold without advance", dataOut, model[10]);
    end

    readWord("R7 setup", 2);
    procStrobeN = 0; chipSelN = 1; addrIn = 4'd9;
    step();
    procStrobeN = 1; chipSelN = 0;
    check("R7 gated strobe ignored", dataOut, model[2]);
    check("R7 gated strobe drive kept", 32'(dataDrive), 32'h1);
    procStrobeN = 0; addrIn = 4'd9;
    step();
    procStrobeN = 1;
    check("R7 gated strobe accepted", dataOut, model[9]);

    for (int v = 0; v < 3; v++) begin
      selectAll();
      if (v == 0) chipSelN = 1;
      if (v == 1) chipSelHi = 0;
      if (v == 2) chipSelLoN = 1;
      ctrlStrobeN = 0; addrIn = 4'd3;
      step();
      check("R1 deselect after one edge", 32'(dataDrive), 32'h0);
      check("R10 bus zero when deselected", dataOut, 32'h0);
      selectAll();
      addrIn = 4'(11 + v);
      step();
      ctrlStrobeN = 1;
      check("R2 enable not yet", 32'(dataDrive), 32'h0);
      step();
      check("R2 enable after second edge", 32'(dataDrive), 32'h1);
      check("R2 data after enable", dataOut, model[11 + v]);
    end

    burstMode = 0;
    readWord("R12 setup", 8);
    advanceN = 0;
    step();
    check("R12 setup advanced", dataOut, model[9]);
    ctrlStrobeN = 0; addrIn = 4'd13;
    step();
    ctrlStrobeN = 1;
    check("R12 start wins over advance", dataOut, model[13]);
    step();
    advanceN = 1;
    check("R12 count restarted", dataOut, model[14]);

    outEnN = 1;
    #1;
    check("R10 output enable off drive", 32'(dataDrive), 32'h0);
    check("R10 output enable off bus", dataOut, 32'h0);
    outEnN = 0;
    #1;
    check("R10 output enable back", dataOut, model[14]);

    readWord("R11 setup", 6);
    sleep = 1;
    #1;
    check("R11 sleep drive off", 32'(dataDrive), 32'h0);
    ctrlStrobeN = 0; addrIn = 4'd12; dataIn = 32'hDEAD_BEEF; globalWriteN = 0; advanceN = 0;
    step();
    clearOps();
    step();
    sleep = 0;
    #1;
    check("R11 address kept through sleep", dataOut, model[6]);
    readWord("R11 no write during sleep", 12);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule